// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface and walks the memory through its mandatory start-up sequence. It waits until the supplies and clock are reported good. It then holds the command bus in DESELECT with the clock enable low for a power-settle window, and raises clock enable for a short NOP window. After that it issues a fixed chain of commands: PRECHARGE ALL, loads of the extended mode registers 2, 3 and 1 (the last one enabling the DLL), a mode-register load that resets the DLL, a second PRECHARGE ALL, and a configurable number of REFRESH commands. When the chain is complete it raises a done flag, and the normal controller takes over.

Each command lasts exactly one clock and is followed by NOP cycles covering the relevant recovery time. The two long windows are given in nanoseconds and converted to clock cycles from a clock-period parameter. The mode-register contents come in on ports. The sequencer forces the few bits that the start-up rules fix: the DLL-enable and off-chip-driver bits of EMR(1), and the DLL-reset bit of MR. The on-die-termination control is tied low for the whole period.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: While reset is active, or while `pwr_stable` is low before done, the outputs are `cke`=0, `cs_n`=1 (DESELECT) and `init_done`=0.
- R2: `odt` is 0 in every cycle.
- R3: After `pwr_stable` rises, the sequencer drives DESELECT with `cke` low for exactly ceil(STABLE_NS*1000/CLK_PERIOD_PS) cycles, counted after the cycle in which the rise is first seen. `cke` then goes high and stays high until reset or a drop of `pwr_stable`.
- R4: With `cke` high, exactly ceil(PRE_NS*1000/CLK_PERIOD_PS) NOP cycles (CS#,RAS#,CAS#,WE# = 0,1,1,1) come before the first PRECHARGE ALL. PRECHARGE ALL is encoded 0,0,1,0 with address bit 10 set, bank 0 and all other address bits 0.
- R5: The second command is LOAD MODE (0,0,0,0) with bank 2 and address `emr2_val`. The third is LOAD MODE with bank 3 and address `emr3_val`.
- R6: The fourth command is LOAD MODE with bank 1 and address `emr_val`, with address bits 0, 7, 8 and 9 forced to 0.
- R7: The fifth command is LOAD MODE with bank 0 and address `mr_val`, with address bit 8 forced to 1.
- R8: The sixth command is a PRECHARGE ALL issued exactly max(T_MRD_CYC, DLL_LOCK_CYC)+1 cycles after the fifth, so at least DLL_LOCK_CYC cycles pass for DLL lock.
- R9: REFRESH_COUNT (at least 2) REFRESH commands (0,0,0,1, bank 0, address 0) follow, each T_RFC_CYC+1 cycles after the one before.
- R10: Every command lasts one cycle. The next command follows T_RP_CYC+1 cycles after the first PRECHARGE ALL and T_MRD_CYC+1 cycles after each of the first three LOAD MODE commands.
- R11: `init_done` rises T_RFC_CYC+1 cycles after the last REFRESH. It then stays high with `cke` high and NOP on the bus until reset, and `pwr_stable` has no effect from then on.
- R12: If `pwr_stable` falls before done, the outputs return to the R1 state in the second clock after the fall. A new rise restarts the whole sequence from R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | Supplies and clock are stable |
| mr_val | input | ROW_W | Mode register contents |
| emr_val | input | ROW_W | Extended mode register 1 contents |
| emr2_val | input | ROW_W | Extended mode register 2 contents |
| emr3_val | input | ROW_W | Extended mode register 3 contents |
| cke | output | 1 | Clock enable |
| odt | output | 1 | On-die termination control |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Address bus |
| init_done | output | 1 | Initialization complete |

## Verification
A wrong state in this sequencer shows up on the command pins within one clock, because the pins are decoded straight from the state register. A stale wait counter changes the spacing between two commands and is caught at the next command. Each command is compared in order against an independently built expected list of kind, bank, address and cycle distance, so a skipped, repeated or misaddressed load shows up where it is issued. Errors in the refresh counter or in done timing appear as a wrong refresh count or a wrong done delay at the end of each sequence.

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq #(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int STABLE_NS     = 200000,
  parameter int PRE_NS        = 400,
  parameter int T_MRD_CYC     = 2,
  parameter int T_RP_CYC      = 3,
  parameter int T_RFC_CYC     = 6,
  parameter int DLL_LOCK_CYC  = 200,
  parameter int REFRESH_COUNT = 2,
  parameter int BA_W          = 3,
  parameter int ROW_W         = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_stable,
  input  logic [ROW_W-1:0] mr_val,
  input  logic [ROW_W-1:0] emr_val,
  input  logic [ROW_W-1:0] emr2_val,
  input  logic [ROW_W-1:0] emr3_val,
  output logic             cke,
  output logic             odt,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             init_done
);
  localparam int STAB_CYC = (STABLE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int PRE_CYC  = (PRE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int LOCK_GAP = (DLL_LOCK_CYC > T_MRD_CYC) ? DLL_LOCK_CYC : T_MRD_CYC;
  localparam int M1 = (STAB_CYC > PRE_CYC) ? STAB_CYC : PRE_CYC;
  localparam int M2 = (LOCK_GAP > T_RFC_CYC) ? LOCK_GAP : T_RFC_CYC;
  localparam int M3 = (T_RP_CYC > M2) ? T_RP_CYC : M2;
  localparam int MAX_CYC = (M1 > M3) ? M1 : M3;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam int REF_W = $clog2(REFRESH_COUNT + 1);
  localparam logic [ROW_W-1:0] EMR_CLR = ROW_W'(14'h0381);
  localparam logic [ROW_W-1:0] DLL_RST = ROW_W'(14'h0100);
  localparam logic [ROW_W-1:0] ALL_BNK = ROW_W'(14'h0400);

  typedef enum logic [3:0] {
    ST_OFF, ST_STAB, ST_CKE, ST_PRE1, ST_EMR2, ST_EMR3, ST_EMR1,
    ST_MR, ST_PRE2, ST_REF, ST_GAP, ST_DONE
  } st_t;

  st_t state, after_gap;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] ref_left;
  logic is_pre, is_lmr, is_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      after_gap <= ST_OFF;
      cnt       <= '0;
      ref_left  <= '0;
    end else if (!pwr_stable && state != ST_DONE) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else begin
      case (state)
        ST_OFF: begin
          state <= ST_STAB;
          cnt   <= CNT_W'(STAB_CYC - 1);
        end
        ST_STAB:
          if (cnt == '0) begin
            state <= ST_CKE;
            cnt   <= CNT_W'(PRE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        ST_CKE:
          if (cnt == '0) state <= ST_PRE1;
          else cnt <= cnt - 1'b1;
        ST_PRE1: begin
          state <= ST_GAP; after_gap <= ST_EMR2; cnt <= CNT_W'(T_RP_CYC - 1);
        end
        ST_EMR2: begin
          state <= ST_GAP; after_gap <= ST_EMR3; cnt <= CNT_W'(T_MRD_CYC - 1);
        end
        ST_EMR3: begin
          state <= ST_GAP; after_gap <= ST_EMR1; cnt <= CNT_W'(T_MRD_CYC - 1);
        end
        ST_EMR1: begin
          state <= ST_GAP; after_gap <= ST_MR; cnt <= CNT_W'(T_MRD_CYC - 1);
        end
        ST_MR: begin
          state <= ST_GAP; after_gap <= ST_PRE2; cnt <= CNT_W'(LOCK_GAP - 1);
        end
        ST_PRE2: begin
          state <= ST_GAP; after_gap <= ST_REF; cnt <= CNT_W'(T_RP_CYC - 1);
          ref_left <= REF_W'(REFRESH_COUNT);
        end
        ST_REF: begin
          state     <= ST_GAP;
          after_gap <= (ref_left == REF_W'(1)) ? ST_DONE : ST_REF;
          cnt       <= CNT_W'(T_RFC_CYC - 1);
          ref_left  <= ref_left - 1'b1;
        end
        ST_GAP:
          if (cnt == '0) state <= after_gap;
          else cnt <= cnt - 1'b1;
        ST_DONE: state <= ST_DONE;
        default: state <= ST_OFF;
      endcase
    end
  end

  assign is_pre    = (state == ST_PRE1) || (state == ST_PRE2);
  assign is_lmr    = (state == ST_EMR2) || (state == ST_EMR3) ||
                     (state == ST_EMR1) || (state == ST_MR);
  assign is_ref    = (state == ST_REF);
  assign cke       = !((state == ST_OFF) || (state == ST_STAB));
  assign odt       = 1'b0;
  assign cs_n      = !cke;
  assign ras_n     = !(is_pre || is_lmr || is_ref);
  assign cas_n     = !(is_lmr || is_ref);
  assign we_n      = !(is_pre || is_lmr);
  assign init_done = (state == ST_DONE);

  always_comb begin
    ba   = '0;
    addr = '0;
    case (state)
      ST_PRE1, ST_PRE2: addr = ALL_BNK;
      ST_EMR2: begin ba = BA_W'(2); addr = emr2_val; end
      ST_EMR3: begin ba = BA_W'(3); addr = emr3_val; end
      ST_EMR1: begin ba = BA_W'(1); addr = emr_val & ~EMR_CLR; end
      ST_MR:   addr = mr_val | DLL_RST;
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2_pwrup_seq_chk.sv
module ddr2_pwrup_seq_chk #(
  parameter int BA_W  = 3,
  parameter int ROW_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_stable,
  input logic             cke,
  input logic             odt,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BA_W-1:0]  ba,
  input logic [ROW_W-1:0] addr,
  input logic             init_done
);
  logic pre_c, lmr_c, any_c;
  assign pre_c = !cs_n && !ras_n && cas_n && !we_n;
  assign lmr_c = !cs_n && !ras_n && !cas_n && !we_n;
  assign any_c = !cs_n && !(ras_n && cas_n && we_n);

  // R2
  odt_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !odt);
  // R1
  off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_stable && !init_done) |=> (!cke && cs_n && !init_done));
  // R3
  cke_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(!pwr_stable));
  // R4
  prea_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_c |-> addr[10]);
  // R6
  emr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lmr_c && ba == BA_W'(1)) |-> (!addr[0] && addr[9:7] == 3'b000));
  // R7
  mr_dllrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lmr_c && ba == '0) |-> addr[8]);
  // R10
  one_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_c |=> !any_c);
  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R11
  done_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cke && !cs_n && ras_n && cas_n && we_n));
endmodule

bind ddr2_pwrup_seq ddr2_pwrup_seq_chk #(.BA_W(BA_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable), .cke(cke), .odt(odt),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
  .addr(addr), .init_done(init_done)
);

// File: tb/ddr2_pwrup_seq_tb.sv
`timescale 1ns/1ps
module ddr2_pwrup_seq_tb;
  localparam int CLK_PS = 20000, STABLE_NS = 200000, PRE_NS = 400;
  localparam int T_MRD = 2, T_RP = 3, T_RFC = 6, DLL_LOCK = 200, NREF = 3;
  localparam int BA_W = 3, ROW_W = 14;
  localparam int STAB_EXP = (STABLE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int PRE_EXP  = (PRE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int LOCK_EXP = (DLL_LOCK > T_MRD) ? DLL_LOCK : T_MRD;
  localparam int NCMD = 6 + NREF;

  logic clk = 1'b0, rst_n = 1'b0, pwr_stable = 1'b0;
  logic [ROW_W-1:0] mr_val = '0, emr_val = '0, emr2_val = '0, emr3_val = '0;
  logic cke, odt, cs_n, ras_n, cas_n, we_n, init_done;
  logic [BA_W-1:0] ba;
  logic [ROW_W-1:0] addr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ddr2_pwrup_seq #(
    .CLK_PERIOD_PS(CLK_PS), .STABLE_NS(STABLE_NS), .PRE_NS(PRE_NS),
    .T_MRD_CYC(T_MRD), .T_RP_CYC(T_RP), .T_RFC_CYC(T_RFC),
    .DLL_LOCK_CYC(DLL_LOCK), .REFRESH_COUNT(NREF), .BA_W(BA_W), .ROW_W(ROW_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable), .mr_val(mr_val),
    .emr_val(emr_val), .emr2_val(emr2_val), .emr3_val(emr3_val), .cke(cke),
    .odt(odt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // kinds: 0 precharge all, 1 load mode, 2 refresh, 3 other
  function automatic int exp_kind(int k);
    if (k == 0 || k == 5) return 0;
    if (k >= 1 && k <= 4) return 1;
    return 2;
  endfunction

  function automatic int exp_ba(int k);
    case (k)
      1: return 2;
      2: return 3;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] exp_addr(int k);
    case (k)
      0, 5: return 14'h0400;
      1: return emr2_val;
      2: return emr3_val;
      3: return emr_val & ~14'h0381;
      4: return mr_val | 14'h0100;
      default: return '0;
    endcase
  endfunction

  function automatic int exp_gap(int k);
    if (k == 0 || k == 5) return T_RP;
    if (k >= 1 && k <= 3) return T_MRD;
    if (k == 4) return LOCK_EXP;
    return T_RFC;
  endfunction

  function automatic string tag(int k);
    case (k)
      0: return "R4";
      1, 2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int kind_now();
    if (cs_n || (ras_n && cas_n && we_n)) return -1;
    if (!ras_n && cas_n && !we_n) return 0;
    if (!ras_n && !cas_n && !we_n) return 1;
    if (!ras_n && !cas_n && we_n) return 2;
    return 3;
  endfunction

  task automatic check_off(input string req, input string what);
    chk(!cke && cs_n && !init_done && !odt, req, what,
        {cke, cs_n, init_done, odt}, 4'b0100);
  endtask

  task automatic run_seq(input int abort_at, output bit aborted);
    int cyc = 0, low = 0, nops = 0, k = 0, last = 0;
    bit seen_hi = 0, fell = 0, odt_bad = 0, desel_bad = 0, hung = 0;
    aborted = 0;
    @(posedge clk); #1 pwr_stable = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (odt) odt_bad = 1;
      if (!cke) begin
        if (seen_hi) fell = 1;
        if (!cs_n) desel_bad = 1;
        low++;
      end else begin
        int kn;
        seen_hi = 1;
        if (init_done) break;
        kn = kind_now();
        if (kn >= 0) begin
          if (k == 0) chk(nops == PRE_EXP, "R4", "NOP cycles before first precharge", nops, PRE_EXP);
          else chk(cyc - last == exp_gap(k - 1) + 1, (k == 5) ? "R8" : (k > 5 ? "R9" : "R10"),
                   "command spacing", cyc - last, exp_gap(k - 1) + 1);
          if (k < NCMD) begin
            chk(kn == exp_kind(k), tag(k), "command kind", kn, exp_kind(k));
            chk(int'(ba) == exp_ba(k), tag(k), "bank", ba, exp_ba(k));
            chk(addr == exp_addr(k), tag(k), "address", addr, exp_addr(k));
          end else chk(0, "R9", "extra command", k, NCMD - 1);
          last = cyc;
          k++;
          if (k - 1 == abort_at) begin
            @(posedge clk); #1 pwr_stable = 1'b0;
            aborted = 1;
            return;
          end
        end else if (k == 0) nops++;
      end
      if (cyc > 20000) begin hung = 1; break; end
    end
    chk(!hung, "R11", "sequence never finished", cyc, 0);
    chk(low == STAB_EXP + 1, "R3", "deselect cycles with cke low", low, STAB_EXP + 1);
    chk(!desel_bad, "R3", "chip selected while cke low", desel_bad, 0);
    chk(!fell, "R3", "cke fell during sequence", fell, 0);
    chk(!odt_bad, "R2", "odt high during sequence", odt_bad, 0);
    chk(k == NCMD, "R9", "commands issued", k, NCMD);
    chk(cyc - last == T_RFC + 1, "R11", "done delay after last refresh", cyc - last, T_RFC + 1);
  endtask

  task automatic after_drop(input string what);
    @(negedge clk);
    @(negedge clk);
    check_off("R12", what);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cke || !cs_n || init_done) begin check_off("R1", "idle after drop"); break; end
    end
    check_off("R1", "idle after drop held");
  endtask

  task automatic set_random();
    mr_val   = ROW_W'($urandom);
    emr_val  = ROW_W'($urandom);
    emr2_val = ROW_W'($urandom);
    emr3_val = ROW_W'($urandom);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pwr_stable = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_off("R1", "outputs in reset");
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ab;
    int n;
    void'($urandom(32'h00c0ffee));
    do_reset();
    repeat (20) @(negedge clk);
    check_off("R1", "idle while power not stable");

    // random drop during the settle window
    n = 10 + int'($urandom % (STAB_EXP - 20));
    @(posedge clk); #1 pwr_stable = 1'b1;
    repeat (n) @(posedge clk);
    #1 pwr_stable = 1'b0;
    after_drop("drop during settle window");

    set_random();
    run_seq(-1, ab);

    // pwr_stable ignored after done
    repeat (5) @(negedge clk);
    @(posedge clk); #1 pwr_stable = 1'b0;
    repeat (10) @(negedge clk);
    chk(init_done && cke && !cs_n && ras_n && cas_n && we_n, "R11",
        "state after done with power flag low", {init_done, cke, cs_n}, 3'b110);

    do_reset();
    set_random();
    run_seq(4, ab);
    chk(ab, "R12", "abort after DLL reset reached", ab, 1);
    after_drop("drop during DLL lock wait");

    set_random();
    run_seq(-1, ab);

    do_reset();
    mr_val = '1; emr_val = '1; emr2_val = '1; emr3_val = '1;
    run_seq(-1, ab);

    do_reset();
    mr_val = '0; emr_val = '0; emr2_val = '0; emr3_val = '0;
    run_seq(-1, ab);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule